// File: doc/BRIEF.md
# Clock Fault Reporting Control Register

This block is a small byte-wide register set for supervising a clock generator. It records losses of the low-frequency reference clock in a sticky flag. It sends each fault to either an interrupt request or a reset request, and it holds the external reference clock source select. The frequency detector, the PLL and the oscillators are outside the block. The detector appears only as a single-cycle loss pulse. The PLL appears only as a loss-of-lock level. The generator mode appears only as a flag that says the external clock is the active source.

Software reaches the block through a byte interface with a write strobe and an address. Offset 0 is the fault control/status register. Offset 1 is the reference select register. Every other offset reads as zero. Reads are registered. The read data shows the register contents as they were at the clock edge that follows the address being presented.

The control/status register has these fields:
- Bit 7: loss-of-reference routing (0 = interrupt, 1 = reset).
- Bit 6: PLL loss-of-lock routing (0 = interrupt, 1 = reset).
- Bit 5: monitor enable.
- Bits 4:1: reserved.
- Bit 0: the sticky loss flag.

Top module: `clk_fault_csr`

## Requirements
- R1: After reset, the control/status register reads 0x80, the reference select reads 0x00, and `loc_irq`, `lol_irq` and `rst_req` are all low.
- R2: Bits 7, 6 and 5 of the control/status register (offset 0) take the written value. Bits 4:1 always read 0 and ignore writes.
- R3: A `loc_pulse` raises the sticky flag (bit 0) at the next edge only while the monitor enable is 1. With the monitor disabled, the pulse leaves the flag at 0 and produces no interrupt and no reset.
- R4: Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves the flag unchanged. If a loss pulse and a clearing write arrive in the same cycle, the flag stays set.
- R5: `loc_irq` is a level equal to flag AND monitor enable AND NOT bit 7, delayed by one cycle.
- R6: When a `loc_pulse` arrives with the monitor enabled and bit 7 at 1, `rst_req` is high for exactly the one cycle after the pulse.
- R7: `lol_irq` is a level equal to `pll_unlock` AND `lol_irq_en` AND NOT bit 6, delayed by one cycle.
- R8: While bit 6 is 1, a rising edge of `pll_unlock` makes `rst_req` high for exactly the one following cycle.
- R9: The reference select at offset 1 is stored in bits 1:0, with 00 = main oscillator 0, 01 = 32 kHz oscillator, 10 = main oscillator 1. Bits 7:2 read 0, and the field is driven on `ref_sel`.
- R10: While `ext_src_active` is high, writes to the reference select are ignored.
- R11: A write of the reserved code 11 leaves the previous selection in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| loc_pulse | input | 1 | Single-cycle loss-of-reference event from the detector |
| pll_unlock | input | 1 | PLL loss-of-lock level |
| lol_irq_en | input | 1 | Loss-of-lock interrupt enable |
| ext_src_active | input | 1 | Generator mode uses the external clock as its source |
| ref_sel | output | 2 | Current reference clock select |
| loc_irq | output | 1 | Loss-of-reference interrupt request |
| lol_irq | output | 1 | PLL loss-of-lock interrupt request |
| rst_req | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- an enabled loss pulse sets the flag, and a clean clearing write clears it;
- a write of 0 to bit 0 leaves the flag alone;
- no interrupt is raised while the monitor is off or while routing selects reset;
- the select never holds the reserved code, and it does not move while the external clock is active;
- the reserved read bits stay at zero.

Some behaviour only the bench scenarios can show. These are the exact readback values, the single-cycle width of the reset pulse, the collision between a loss event and a clearing write, and the table walk through the select writes that are allowed and blocked.

// File: rtl/clk_fault_pkg.sv
package clk_fault_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned BIT_LOC_RST = 7;
  localparam int unsigned BIT_LOL_RST = 6;
  localparam int unsigned BIT_MON_EN  = 5;
  localparam int unsigned BIT_FLAG    = 0;
  localparam logic [REG_W-1:0] CTRL_RST_VAL = 8'h80;
  localparam logic [REG_W-1:0] CTRL_RW_MASK = 8'hE0;
  typedef enum logic [SEL_W-1:0] {
    REF_OSC0  = 2'b00,
    REF_LF32K = 2'b01,
    REF_OSC1  = 2'b10,
    REF_RSVD  = 2'b11
  } ref_sel_e;
endpackage

// File: rtl/clk_fault_ctrl_reg.sv
module clk_fault_ctrl_reg
  import clk_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             loc_event,
  output logic [REG_W-1:0] ctrl_q
);
  logic set_flag;
  logic clr_flag;

  assign set_flag = loc_event & ctrl_q[BIT_MON_EN];
  assign clr_flag = wr_ctrl & wdata[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST_VAL;
    end else begin
      if (wr_ctrl)
        ctrl_q <= (ctrl_q & ~CTRL_RW_MASK) | (wdata & CTRL_RW_MASK);
      if (set_flag)
        ctrl_q[BIT_FLAG] <= 1'b1;
      else if (clr_flag)
        ctrl_q[BIT_FLAG] <= 1'b0;
    end
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_event && ctrl_q[BIT_MON_EN]) |=> ctrl_q[BIT_FLAG]);
  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[BIT_FLAG] && !(loc_event && ctrl_q[BIT_MON_EN])) |=> !ctrl_q[BIT_FLAG]);
  // R4
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!(wr_ctrl && wdata[BIT_FLAG]) && !(loc_event && ctrl_q[BIT_MON_EN])) |=> $stable(ctrl_q[BIT_FLAG]));
endmodule

// File: rtl/clk_fault_refsel.sv
module clk_fault_refsel
  import clk_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [SEL_W-1:0] wsel,
  input  logic             ext_src_active,
  output logic [SEL_W-1:0] sel_q
);
  logic accept;

  assign accept = wr_sel & ~ext_src_active & (wsel != REF_RSVD);

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= REF_OSC0;
    else if (accept)
      sel_q <= wsel;
  end

  // R10
  sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
    ext_src_active |=> $stable(sel_q));
  // R11
  sel_no_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q != REF_RSVD);
endmodule

// File: rtl/clk_fault_router.sv
module clk_fault_router (
  input  logic clk,
  input  logic rst,
  input  logic loc_event,
  input  logic pll_unlock,
  input  logic lol_irq_en,
  input  logic mon_en,
  input  logic loc_rst_sel,
  input  logic lol_rst_sel,
  input  logic loc_flag,
  output logic loc_irq,
  output logic lol_irq,
  output logic rst_req
);
  logic unlock_d;
  logic loc_rst_hit;
  logic lol_rst_hit;

  assign loc_rst_hit = loc_event & mon_en & loc_rst_sel;
  assign lol_rst_hit = pll_unlock & ~unlock_d & lol_rst_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_d <= 1'b0;
      loc_irq  <= 1'b0;
      lol_irq  <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      unlock_d <= pll_unlock;
      loc_irq  <= loc_flag & mon_en & ~loc_rst_sel;
      lol_irq  <= pll_unlock & lol_irq_en & ~lol_rst_sel;
      rst_req  <= loc_rst_hit | lol_rst_hit;
    end
  end

  // R3
  mon_off_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> !loc_irq);
  // R5
  loc_route_rst_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    loc_rst_sel |=> !loc_irq);
  // R6
  loc_rst_req_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_event && mon_en && loc_rst_sel) |=> rst_req);
  // R7
  lol_ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!lol_irq_en || lol_rst_sel) |=> !lol_irq);
endmodule

// File: rtl/clk_fault_csr.sv
module clk_fault_csr
  import clk_fault_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned SEL_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              loc_pulse,
  input  logic              pll_unlock,
  input  logic              lol_irq_en,
  input  logic              ext_src_active,
  output logic [1:0]        ref_sel,
  output logic              loc_irq,
  output logic              lol_irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);

  logic             hit_ctrl;
  logic             hit_sel;
  logic [REG_W-1:0] ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic [REG_W-1:0] rd_mux;

  assign hit_ctrl = (addr == CTRL_A);
  assign hit_sel  = (addr == SEL_A);

  clk_fault_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_en & hit_ctrl),
    .wdata     (wdata),
    .loc_event (loc_pulse),
    .ctrl_q    (ctrl_q)
  );

  clk_fault_refsel u_sel (
    .clk            (clk),
    .rst            (rst),
    .wr_sel         (wr_en & hit_sel),
    .wsel           (wdata[SEL_W-1:0]),
    .ext_src_active (ext_src_active),
    .sel_q          (sel_q)
  );

  clk_fault_router u_route (
    .clk         (clk),
    .rst         (rst),
    .loc_event   (loc_pulse),
    .pll_unlock  (pll_unlock),
    .lol_irq_en  (lol_irq_en),
    .mon_en      (ctrl_q[BIT_MON_EN]),
    .loc_rst_sel (ctrl_q[BIT_LOC_RST]),
    .lol_rst_sel (ctrl_q[BIT_LOL_RST]),
    .loc_flag    (ctrl_q[BIT_FLAG]),
    .loc_irq     (loc_irq),
    .lol_irq     (lol_irq),
    .rst_req     (rst_req)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)
      rd_mux = ctrl_q;
    else if (hit_sel)
      rd_mux = {{(REG_W-SEL_W){1'b0}}, sel_q};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= rd_mux;
  end

  assign ref_sel = sel_q;

  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl |=> (rdata[4:1] == 4'b0000));
  // R9
  sel_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hit_sel |=> (rdata[7:2] == 6'b000000));
endmodule

// File: tb/tb_clk_fault_csr.sv
module tb_clk_fault_csr;
  localparam int ADDR_W = 4;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic loc_pulse = 1'b0;
  logic pll_unlock = 1'b0;
  logic lol_irq_en = 1'b0;
  logic ext_src_active = 1'b0;
  logic [1:0] ref_sel;
  logic loc_irq, lol_irq, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  // vector: {ext_active, write byte, expected select}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 2'b01},
    {1'b0, 8'h02, 2'b10},
    {1'b0, 8'h03, 2'b10},
    {1'b1, 8'h00, 2'b10},
    {1'b1, 8'h01, 2'b10},
    {1'b0, 8'hFC, 2'b00},
    {1'b0, 8'hFF, 2'b00},
    {1'b0, 8'h01, 2'b01}
  };

  clk_fault_csr #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .loc_pulse(loc_pulse), .pll_unlock(pll_unlock),
    .lol_irq_en(lol_irq_en), .ext_src_active(ext_src_active),
    .ref_sel(ref_sel), .loc_irq(loc_irq), .lol_irq(lol_irq), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse_loc();
    @(negedge clk);
    loc_pulse = 1'b1;
    @(negedge clk);
    loc_pulse = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 outs", {5'b0, loc_irq, lol_irq, rst_req}, 8'h00);
    rd(4'd0, rv); check("R1 ctrl", rv, 8'h80);
    rd(4'd1, rv); check("R1 sel", rv, 8'h00);

    // R9 R10 R11 table walk over select writes
    for (int i = 0; i < NVEC; i++) begin
      ext_src_active = VEC[i][10];
      wr(4'd1, VEC[i][9:2]);
      ext_src_active = 1'b0;
      check("R9/R10/R11 port", {6'b0, ref_sel}, {6'b0, VEC[i][1:0]});
      rd(4'd1, rv);
      check("R9 readback", rv, {6'b0, VEC[i][1:0]});
    end

    // R2 reserved bits ignore writes
    wr(4'd0, 8'hFE); rd(4'd0, rv); check("R2 rw+rsvd", rv, 8'hE0);
    wr(4'd0, 8'h1E); rd(4'd0, rv); check("R2 rsvd only", rv, 8'h00);
    rd(4'd5, rv); check("R2 unmapped", rv, 8'h00);

    // R3 monitor disabled: no flag, irq, reset
    wr(4'd0, 8'h80);
    pulse_loc();
    check("R3 no rst", {7'b0, rst_req}, 8'h00);
    @(negedge clk); check("R3 no irq", {7'b0, loc_irq}, 8'h00);
    rd(4'd0, rv); check("R3 no flag", rv, 8'h80);

    // R5 interrupt routing
    wr(4'd0, 8'h20);
    pulse_loc();
    check("R5 no rst", {7'b0, rst_req}, 8'h00);
    @(negedge clk); check("R5 irq", {7'b0, loc_irq}, 8'h01);
    rd(4'd0, rv); check("R3 flag set", rv, 8'h21);
    // R4 write 0 keeps, write 1 clears
    wr(4'd0, 8'h20); rd(4'd0, rv); check("R4 w0 keep", rv, 8'h21);
    wr(4'd0, 8'h21); rd(4'd0, rv); check("R4 w1c", rv, 8'h20);
    check("R5 irq drops", {7'b0, loc_irq}, 8'h00);

    // R6 reset routing
    wr(4'd0, 8'hA0);
    pulse_loc();
    check("R6 rst pulse", {7'b0, rst_req}, 8'h01);
    @(negedge clk); check("R6 rst one cycle", {7'b0, rst_req}, 8'h00);
    check("R5 no irq when reset routed", {7'b0, loc_irq}, 8'h00);
    rd(4'd0, rv); check("R6 flag", rv, 8'hA1);

    // R4 collision: event beats clear
    @(negedge clk);
    addr = 4'd0; wdata = 8'hA1; wr_en = 1'b1; loc_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; loc_pulse = 1'b0;
    rd(4'd0, rv); check("R4 collision", rv, 8'hA1);
    wr(4'd0, 8'h01); rd(4'd0, rv); check("R4 clear", rv, 8'h00);

    // R7 loss of lock interrupt
    @(negedge clk); pll_unlock = 1'b1; lol_irq_en = 1'b0;
    @(negedge clk); check("R7 ie off", {7'b0, lol_irq}, 8'h00);
    check("R8 no rst when irq routed", {7'b0, rst_req}, 8'h00);
    lol_irq_en = 1'b1;
    @(negedge clk); check("R7 irq", {7'b0, lol_irq}, 8'h01);
    pll_unlock = 1'b0;
    @(negedge clk); check("R7 irq level drop", {7'b0, lol_irq}, 8'h00);

    // R8 loss of lock reset
    wr(4'd0, 8'h40);
    @(negedge clk); pll_unlock = 1'b1;
    @(negedge clk); check("R8 rst pulse", {7'b0, rst_req}, 8'h01);
    check("R7 no irq when reset routed", {7'b0, lol_irq}, 8'h00);
    @(negedge clk); check("R8 rst one cycle", {7'b0, rst_req}, 8'h00);
    pll_unlock = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule